// File: doc/BRIEF.md
# Two-Wire Serial Memory Target

This block is the target side of a two-wire serial bus in front of a 256-byte memory. SCL and SDA are sampled with the system clock. A short synchronizer feeds an edge detector, which finds Start and Stop conditions and the bit clock edges. The first byte after a Start selects the block. Its top nibble holds the command code, the next three bits must equal the `cs_strap` pins, and the least significant bit selects the direction.

A write carries a word address into the 8-bit address pointer. Any data bytes that follow go into a 16-byte page buffer. After the Stop, the buffer is copied into the memory array during an internal write cycle that lasts a fixed number of clocks. Reads start at the pointer and step forward one byte at a time. This covers three cases: a current-address read, a random read (the address is set, then a repeated Start), and a sequential read. A second command code lets software lock the lower half of the array against writes, permanently until reset. The block pulls SDA low through `sda_oe`, open-drain style, both for its acknowledge bits and for its read data.

Top module: `i2c_ee_target`

## Requirements
- R1: A Start (SDA falling while SCL is high) begins a new control byte from any state, including in the middle of a byte. A Stop (SDA rising while SCL is high) ends the transfer and releases SDA.
- R2: The control byte is sent MSB first. Bits 7:4 are the command code, bits 3:1 must equal `cs_strap`, and bit 0 is the direction (1 = read). On a chip-select mismatch there is no acknowledge, and the block stays silent until the next Start or Stop.
- R3: Code 1010 is acknowledged for both reads and writes. Code 0110 is acknowledged only for a write, and only while the lower-half lock is clear. Every other code is not acknowledged.
- R4: In a write, the byte after the control byte is loaded into the 8-bit address pointer. A repeated Start after that byte writes nothing to the memory (random read).
- R5: Write data bytes are acknowledged and placed in the page buffer at the pointer's low 4 bits. Only those 4 bits step after each byte, so the data wraps within the 16-byte page and later bytes overwrite earlier ones. The buffer reaches the memory only after a Stop.
- R6: For WRITE_CYCLES clocks after a Stop that ends a write with data, no byte is acknowledged, including the control byte, and SDA is not driven.
- R7: A read sends the byte at the pointer MSB first, then steps the pointer by one. It wraps from FFh to 00h. A master ACK gets the next byte. A master NACK leaves SDA released until the next Start or Stop.
- R8: A current-address read returns the byte at the last accessed address plus one.
- R9: A 0110 write (control byte, address byte, data byte, Stop) sets the lower-half lock. After that, writes to 00h-7Fh leave the memory unchanged, writes to 80h-FFh still land, and the lock stays set until reset.
- R10: `sda_oe` changes only while SCL is low, and at least one clock after the SCL falling edge has been seen.
- R11: Reset releases SDA, clears the pointer to 00h and clears the lock. Memory contents are kept across reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen on the wire |
| sda_i | input | 1 | Bus data line as seen on the wire |
| cs_strap | input | 3 | Chip-select strap compared with control byte bits 3:1 |
| sda_oe | output | 1 | 1 pulls SDA low (acknowledge or a zero data bit) |

## Verification
A full fill of all sixteen pages, followed by a 16-byte read, shows the page buffer and the sequential read working together. A read starting at FEh separates a pointer that wraps over all 8 bits from one that wraps only within the page. A 20-byte write into the middle of a page exposes the overwrite order. Acknowledge polling straight after each Stop must see at least one NACK, which distinguishes a real internal write cycle from an immediate ready.

Random page writes, random reads and current-address reads run against a bench memory model. Directed cases cover:
- a chip-select mismatch;
- foreign command codes;
- a protect-code read;
- a Start in the middle of a byte;
- a reset in the middle of the run, which must keep the memory but clear the pointer;
- writes on both sides of the half-array lock.

// File: rtl/i2c_ee_pkg.sv
package i2c_ee_pkg;
  localparam int BYTE_W = 8;
  localparam int CODE_W = 4;
  localparam int SEL_W  = 3;
  localparam logic [CODE_W-1:0] CODE_ARRAY = 4'b1010;
  localparam logic [CODE_W-1:0] CODE_LOCK  = 4'b0110;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_CTRL  = 3'd1,
    ST_ADDR  = 3'd2,
    ST_WDATA = 3'd3,
    ST_RDATA = 3'd4,
    ST_SKIP  = 3'd5
  } tgt_state_t;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_q,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  localparam int MSB = SYNC_STAGES - 1;

  logic [MSB:0] scl_sh, sda_sh;
  logic scl_p, sda_p, scl_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_p  <= 1'b1;
      sda_p  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[MSB-1:0], scl_i};
      sda_sh <= {sda_sh[MSB-1:0], sda_i};
      scl_p  <= scl_sh[MSB];
      sda_p  <= sda_sh[MSB];
    end
  end

  assign scl_q     = scl_sh[MSB];
  assign sda_q     = sda_sh[MSB];
  assign scl_rise  = scl_q & ~scl_p;
  assign scl_fall  = ~scl_q & scl_p;
  assign start_det = scl_q & scl_p & sda_p & ~sda_q;
  assign stop_det  = scl_q & scl_p & ~sda_p & sda_q;
endmodule

// File: rtl/i2c_mem_array.sv
module i2c_mem_array #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/i2c_page_commit.sv
module i2c_page_commit #(
  parameter int AW           = 8,
  parameter int DW           = 8,
  parameter int PW           = 4,
  parameter int WRITE_CYCLES = 512
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_en,
  input  logic [PW-1:0] load_idx,
  input  logic [DW-1:0] load_data,
  input  logic [AW-PW-1:0] load_page,
  input  logic          discard,
  input  logic          go,
  input  logic          lock_lo,
  output logic          busy,
  output logic          mem_we,
  output logic [AW-1:0] mem_waddr,
  output logic [DW-1:0] mem_wdata
);
  localparam int PAGE  = 1 << PW;
  localparam int PGA_W = AW - PW;
  localparam int CW    = $clog2(WRITE_CYCLES + 1);

  logic [DW-1:0]    buf_data [PAGE];
  logic [PAGE-1:0]  buf_vld;
  logic [PGA_W-1:0] page_q;
  logic [CW-1:0]    cyc;
  logic [PW-1:0]    cyc_idx;
  logic             in_window, blocked;

  assign cyc_idx   = cyc[PW-1:0];
  assign in_window = cyc < CW'(PAGE);
  assign blocked   = lock_lo & ~page_q[PGA_W-1];

  always_ff @(posedge clk) begin
    if (!busy && !go && load_en) buf_data[load_idx] <= load_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      buf_vld   <= '0;
      page_q    <= '0;
      cyc       <= '0;
      busy      <= 1'b0;
      mem_we    <= 1'b0;
      mem_waddr <= '0;
      mem_wdata <= '0;
    end else begin
      mem_we <= 1'b0;
      if (busy) begin
        if (in_window) begin
          mem_we    <= buf_vld[cyc_idx] & ~blocked;
          mem_waddr <= {page_q, cyc_idx};
          mem_wdata <= buf_data[cyc_idx];
        end
        if (cyc == CW'(WRITE_CYCLES - 1)) begin
          busy    <= 1'b0;
          buf_vld <= '0;
        end
        cyc <= cyc + 1'b1;
      end else if (go) begin
        busy <= 1'b1;
        cyc  <= '0;
      end else begin
        if (discard) buf_vld <= '0;
        if (load_en) begin
          buf_vld[load_idx] <= 1'b1;
          page_q            <= load_page;
        end
      end
    end
  end
endmodule

// File: rtl/i2c_ee_target.sv
module i2c_ee_target
  import i2c_ee_pkg::*;
#(
  parameter int AW           = 8,
  parameter int PW           = 4,
  parameter int WRITE_CYCLES = 512,
  parameter int SYNC_STAGES  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             scl_i,
  input  logic             sda_i,
  input  logic [SEL_W-1:0] cs_strap,
  output logic             sda_oe
);
  localparam int PGA_W = AW - PW;

  logic sda_q, scl_rise, scl_fall, start_det, stop_det;

  i2c_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .sda_q(sda_q), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  tgt_state_t        state;
  logic [3:0]        bit_cnt;
  logic [BYTE_W-1:0] rx_sr, tx_sr;
  logic [AW-1:0]     ptr;
  logic              lock_mode, lock_set, wr_pend, lock_pend, master_ack;
  logic              buf_load, buf_discard, commit_go;
  logic [PW-1:0]     load_idx;
  logic [BYTE_W-1:0] load_data;
  logic [PGA_W-1:0]  load_page;
  logic              wr_busy, mem_we;
  logic [AW-1:0]     mem_waddr;
  logic [BYTE_W-1:0] mem_wdata, rd_q;

  i2c_page_commit #(.AW(AW), .DW(BYTE_W), .PW(PW), .WRITE_CYCLES(WRITE_CYCLES)) u_commit (
    .clk(clk), .rst(rst), .load_en(buf_load), .load_idx(load_idx),
    .load_data(load_data), .load_page(load_page), .discard(buf_discard),
    .go(commit_go), .lock_lo(lock_set), .busy(wr_busy),
    .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata)
  );

  i2c_mem_array #(.AW(AW), .DW(BYTE_W)) u_mem (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr(ptr), .rdata(rd_q)
  );

  logic [CODE_W-1:0] rx_code;
  logic [SEL_W-1:0]  rx_sel;
  logic              rx_rd, ctrl_ok;

  assign rx_code = rx_sr[7:4];
  assign rx_sel  = rx_sr[3:1];
  assign rx_rd   = rx_sr[0];
  assign ctrl_ok = !wr_busy && (rx_sel == cs_strap) &&
                   ((rx_code == CODE_ARRAY) ||
                    (rx_code == CODE_LOCK && !rx_rd && !lock_set));

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      bit_cnt     <= '0;
      rx_sr       <= '0;
      tx_sr       <= '0;
      ptr         <= '0;
      sda_oe      <= 1'b0;
      lock_mode   <= 1'b0;
      lock_set    <= 1'b0;
      wr_pend     <= 1'b0;
      lock_pend   <= 1'b0;
      master_ack  <= 1'b0;
      buf_load    <= 1'b0;
      buf_discard <= 1'b0;
      commit_go   <= 1'b0;
      load_idx    <= '0;
      load_data   <= '0;
      load_page   <= '0;
    end else begin
      buf_load    <= 1'b0;
      buf_discard <= 1'b0;
      commit_go   <= 1'b0;
      if (start_det) begin
        state       <= ST_CTRL;
        bit_cnt     <= '0;
        sda_oe      <= 1'b0;
        wr_pend     <= 1'b0;
        lock_pend   <= 1'b0;
        buf_discard <= 1'b1;
      end else if (stop_det) begin
        state     <= ST_IDLE;
        bit_cnt   <= '0;
        sda_oe    <= 1'b0;
        commit_go <= wr_pend | lock_pend;
        if (lock_pend) lock_set <= 1'b1;
        wr_pend   <= 1'b0;
        lock_pend <= 1'b0;
      end else begin
        if (scl_rise && state != ST_IDLE && state != ST_SKIP) begin
          if (bit_cnt < 4'd8) rx_sr <= {rx_sr[BYTE_W-2:0], sda_q};
          if (bit_cnt == 4'd8) master_ack <= ~sda_q;
          bit_cnt <= bit_cnt + 1'b1;
        end
        if (scl_fall) begin
          case (state)
            ST_CTRL: begin
              if (bit_cnt == 4'd8) begin
                if (ctrl_ok) begin
                  sda_oe    <= 1'b1;
                  lock_mode <= (rx_code == CODE_LOCK);
                end else begin
                  state <= ST_SKIP;
                end
              end else if (bit_cnt == 4'd9) begin
                bit_cnt <= '0;
                if (rx_rd) begin
                  state  <= ST_RDATA;
                  tx_sr  <= rd_q;
                  sda_oe <= ~rd_q[BYTE_W-1];
                  ptr    <= ptr + 1'b1;
                end else begin
                  state  <= ST_ADDR;
                  sda_oe <= 1'b0;
                end
              end
            end
            ST_ADDR: begin
              if (bit_cnt == 4'd8) begin
                sda_oe <= 1'b1;
                if (!lock_mode) ptr <= rx_sr[AW-1:0];
              end else if (bit_cnt == 4'd9) begin
                sda_oe  <= 1'b0;
                bit_cnt <= '0;
                state   <= ST_WDATA;
              end
            end
            ST_WDATA: begin
              if (bit_cnt == 4'd8) begin
                sda_oe <= 1'b1;
                if (lock_mode) begin
                  lock_pend <= 1'b1;
                end else begin
                  buf_load  <= 1'b1;
                  load_idx  <= ptr[PW-1:0];
                  load_data <= rx_sr;
                  load_page <= ptr[AW-1:PW];
                  ptr       <= {ptr[AW-1:PW], ptr[PW-1:0] + 1'b1};
                  wr_pend   <= 1'b1;
                end
              end else if (bit_cnt == 4'd9) begin
                sda_oe  <= 1'b0;
                bit_cnt <= '0;
              end
            end
            ST_RDATA: begin
              if (bit_cnt >= 4'd1 && bit_cnt <= 4'd7) begin
                sda_oe <= ~tx_sr[BYTE_W-2];
                tx_sr  <= {tx_sr[BYTE_W-2:0], 1'b0};
              end else if (bit_cnt == 4'd8) begin
                sda_oe <= 1'b0;
              end else if (bit_cnt == 4'd9) begin
                bit_cnt <= '0;
                if (master_ack) begin
                  tx_sr  <= rd_q;
                  sda_oe <= ~rd_q[BYTE_W-1];
                  ptr    <= ptr + 1'b1;
                end else begin
                  state <= ST_SKIP;
                end
              end
            end
            default: ;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/i2c_ee_target_chk.sv
module i2c_ee_target_chk #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          scl_i,
  input logic          sda_oe,
  input logic          busy,
  input logic          mem_we,
  input logic [AW-1:0] mem_waddr,
  input logic          lock_set,
  input logic [2:0]    state
);
  assert_sda_moves_low_R10: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_oe) |-> !scl_i);

  assert_silent_when_busy_R6: assert property (@(posedge clk) disable iff (rst)
    busy |-> !sda_oe);

  assert_array_write_in_cycle_R5: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> busy);

  assert_lower_half_locked_R9: assert property (@(posedge clk) disable iff (rst)
    (mem_we && lock_set) |-> mem_waddr[AW-1]);

  assert_lock_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    lock_set |=> lock_set);

  assert_idle_released_R1: assert property (@(posedge clk) disable iff (rst)
    (state == 3'd0) |-> !sda_oe);
endmodule

bind i2c_ee_target i2c_ee_target_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .scl_i(scl_i), .sda_oe(sda_oe), .busy(wr_busy),
  .mem_we(mem_we), .mem_waddr(mem_waddr), .lock_set(lock_set), .state(state)
);

// File: tb/i2c_ee_target_tb.sv
module i2c_ee_target_tb;
  localparam int Q = 5;
  localparam logic [2:0] SEL = 3'b101;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  logic sda_line;

  always #2 clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  i2c_ee_target u_dut (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line),
    .cs_strap(SEL), .sda_oe(sda_oe)
  );

  int nchk = 0;
  int nerr = 0;
  int viol = 0;
  logic [7:0] model [256];
  logic [7:0] wbuf [32];
  logic [7:0] mptr = 8'h00;
  bit mlock = 1'b0;
  logic oe_p = 1'b0;

  always @(negedge clk) begin
    if (!rst && sda_oe !== oe_p && scl_m) viol++;
    oe_p <= sda_oe;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] ctl(input logic [3:0] code, input logic [2:0] sel,
                                     input logic rd);
    return {code, sel, rd};
  endfunction

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic put_bit(input logic b);
    sda_m = b; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq();
  endtask

  task automatic get_bit(output logic b);
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); b = sda_line; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq(); wq();
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    logic a;
    for (int i = 7; i >= 0; i--) put_bit(b[i]);
    get_bit(a);
    ack = !a;
  endtask

  task automatic recv_byte(input bit mack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) get_bit(b[i]);
    put_bit(!mack);
  endtask

  task automatic wait_ready(output int nacks);
    bit a;
    nacks = 0;
    for (int k = 0; k < 40; k++) begin
      bus_start(); send_byte(ctl(4'b1010, SEL, 1'b0), a); bus_stop();
      if (a) break;
      nacks++;
    end
  endtask

  task automatic write_seq(input logic [7:0] addr, input int n);
    logic [7:0] pb [16];
    bit pv [16];
    bit a;
    int nk;
    logic [3:0] idx;
    for (int i = 0; i < 16; i++) pv[i] = 1'b0;
    bus_start();
    send_byte(ctl(4'b1010, SEL, 1'b0), a); chk(a, "R5", "write ctrl ack", a, 1);
    send_byte(addr, a); chk(a, "R4", "address ack", a, 1);
    for (int i = 0; i < n; i++) begin
      send_byte(wbuf[i], a); chk(a, "R5", "data ack", a, 1);
      idx = addr[3:0] + 4'(i);
      pb[idx] = wbuf[i]; pv[idx] = 1'b1;
    end
    bus_stop();
    for (int i = 0; i < 16; i++) begin
      logic [7:0] ad;
      ad = {addr[7:4], 4'(i)};
      if (pv[i] && !(mlock && !ad[7])) model[ad] = pb[i];
    end
    mptr = {addr[7:4], addr[3:0] + 4'(n)};
    wait_ready(nk);
    chk(nk >= 1 && nk < 40, "R6", "busy nack polls", nk, 1);
  endtask

  task automatic read_rand(input logic [7:0] addr, input int n, input string req);
    bit a;
    logic [7:0] b;
    bus_start();
    send_byte(ctl(4'b1010, SEL, 1'b0), a); chk(a, "R4", "ctrl ack", a, 1);
    send_byte(addr, a); chk(a, "R4", "address ack", a, 1);
    bus_start();
    send_byte(ctl(4'b1010, SEL, 1'b1), a); chk(a, "R7", "read ctrl ack", a, 1);
    for (int i = 0; i < n; i++) begin
      recv_byte(i < n - 1, b);
      chk(b === model[8'(addr + 8'(i))], req, "read data", b, model[8'(addr + 8'(i))]);
    end
    bus_stop();
    mptr = addr + 8'(n);
  endtask

  task automatic read_cur(input int n, input string req);
    bit a;
    logic [7:0] b;
    bus_start();
    send_byte(ctl(4'b1010, SEL, 1'b1), a); chk(a, req, "cur read ack", a, 1);
    for (int i = 0; i < n; i++) begin
      recv_byte(i < n - 1, b);
      chk(b === model[mptr], req, "current address data", b, model[mptr]);
      mptr = mptr + 1'b1;
    end
    bus_stop();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    bit a;
    int nk;
    logic [7:0] b;
    void'($urandom(32'd4711));
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk(sda_oe === 1'b0, "R11", "sda released after reset", sda_oe, 0);

    // R5: fill every page
    for (int p = 0; p < 16; p++) begin
      for (int i = 0; i < 16; i++) wbuf[i] = 8'($urandom);
      write_seq(8'(p * 16), 16);
    end
    read_rand(8'h00, 16, "R7");
    read_rand(8'hFE, 4, "R7");      // R7 pointer wrap FFh -> 00h
    read_cur(2, "R8");

    // R11: reset keeps memory, clears pointer
    rst = 1'b1; repeat (3) @(negedge clk); rst = 1'b0; repeat (3) @(negedge clk);
    mptr = 8'h00;
    read_cur(1, "R11");

    // R5: overwrite within page
    for (int i = 0; i < 20; i++) wbuf[i] = 8'($urandom);
    write_seq(8'h37, 20);
    read_rand(8'h30, 16, "R5");

    // R2 / R3 rejections
    bus_start(); send_byte(ctl(4'b1010, 3'b010, 1'b0), a);
    chk(!a, "R2", "chip select mismatch nack", a, 0);
    send_byte(8'h00, a); chk(!a, "R2", "silent after mismatch", a, 0);
    bus_stop();
    bus_start(); send_byte(ctl(4'b1011, SEL, 1'b0), a); bus_stop();
    chk(!a, "R3", "foreign code nack", a, 0);
    bus_start(); send_byte(ctl(4'b0110, SEL, 1'b1), a); bus_stop();
    chk(!a, "R3", "lock code read nack", a, 0);

    // R1: Start in the middle of a byte
    bus_start(); put_bit(1'b1); put_bit(1'b0); put_bit(1'b1);
    bus_start(); send_byte(ctl(4'b1010, SEL, 1'b1), a);
    chk(a, "R1", "ack after restart", a, 1);
    recv_byte(1'b0, b);
    chk(b === model[mptr], "R1", "data after restart", b, model[mptr]);
    mptr = mptr + 1'b1;
    bus_stop();
    chk(sda_oe === 1'b0, "R1", "released after stop", sda_oe, 0);

    // random mix
    for (int it = 0; it < 6; it++) begin
      int n;
      logic [7:0] ad;
      n = 1 + int'($urandom % 16);
      ad = 8'($urandom);
      for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
      write_seq(ad, n);
      read_cur(1 + int'($urandom % 3), "R8");
      read_rand(8'($urandom), 1 + int'($urandom % 8), "R7");
    end

    // R9: lower-half lock
    bus_start();
    send_byte(ctl(4'b0110, SEL, 1'b0), a); chk(a, "R9", "lock ctrl ack", a, 1);
    send_byte(8'h00, a); chk(a, "R9", "lock addr ack", a, 1);
    send_byte(8'hFF, a); chk(a, "R9", "lock data ack", a, 1);
    bus_stop();
    wait_ready(nk);
    chk(nk >= 1 && nk < 40, "R6", "busy after lock", nk, 1);
    mlock = 1'b1;
    wbuf[0] = ~model[8'h20]; wbuf[1] = ~model[8'h21];
    write_seq(8'h20, 2);
    read_rand(8'h20, 2, "R9");
    wbuf[0] = ~model[8'hA0]; wbuf[1] = ~model[8'hA1];
    write_seq(8'hA0, 2);
    read_rand(8'hA0, 2, "R9");
    bus_start(); send_byte(ctl(4'b0110, SEL, 1'b0), a); bus_stop();
    chk(!a, "R9", "lock code refused once set", a, 0);

    chk(viol == 0, "R10", "sda_oe changes while SCL high", viol, 0);
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule